// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing core of a pulse-width modulator. A single 16-bit control word chooses how the counter moves, when it is allowed to stop, how a new period takes effect and how far the input clock is slowed down. The prescaler multiplies two dividers. One divides by a power of two. The other divides by 1 at code 0 and by twice its code above that. Each time the prescaler expires it produces a tick, and each tick moves a 16-bit counter against an active period value.

The active period can be written directly. It can also be staged in a shadow copy that moves into the active register when the counter passes through zero. Downstream compare and action logic reads the live count, a zero-match strobe and a period-match strobe. Software reaches the two registers through a one-cycle write port: `wr_sel` 0 selects control and 1 selects period.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the control word, the count and both periods are 0. Both strobes are low, and the counter stays stopped because the run field reads 0.
- R2: A tick occurs once every F clocks, with F = A × 2^K. K is control bits [12:10]. A is 1 when control bits [9:7] are 0, and twice that code otherwise.
- R3: With count mode 0 (control bits [1:0]), each tick adds one to the counter. A tick that finds the count at or above the active period loads 0 instead.
- R4: With count mode 1, each tick takes one off the counter. A tick at 0 reloads the period that is active after that tick.
- R5: With count mode 2, the counter rises to the active period and then falls back to 0, reversing direction at each end.
- R6: With count mode 3, the counter holds its value and neither strobe is raised.
- R7: Run field 0 (control bits [15:14]) lets the counter take exactly one more tick and then hold it. Run codes 2 and 3 free-run and release any hold; the held value persists until one of them is written.
- R8: Run field 1 lets the counter keep going until a tick leaves it at 0, and then holds it there.
- R9: With control bit 3 set, a period write changes the active period on the next clock.
- R10: With control bit 3 clear, a period write goes to the shadow copy, which becomes active on the next tick that finds the count at 0. If such a write coincides with that tick, the written value becomes active.
- R11: `zero_evt` is high for exactly the clock in which a tick will advance a counter that reads 0. `prd_evt` does the same for a count equal to the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = period |
| wr_data | input | 16 | Write data |
| cnt_q | output | 16 | Current counter value |
| zero_evt | output | 1 | Zero-match strobe |
| prd_evt | output | 1 | Period-match strobe |

## Verification
Two things can fall in the same clock: a period write in shadow mode, and the zero-tick transfer of the shadow copy into the active period. The bench steps the counter until `zero_evt` is high and issues the period write in that very clock. The written value must then govern the following cycle and the down-count reload, and a reference model built from the requirements judges the count on every clock after it. The same model also follows random mixes of control and period writes, so stop requests landing on wrap ticks are covered as well.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [15:0]      wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_evt,
  output logic             prd_evt
);
  localparam int DMAX   = (1 << DIV_W) - 1;
  localparam int PS_MAX = (1 << DMAX) * 2 * DMAX;
  localparam int PS_W   = $clog2(PS_MAX + 1);
  localparam int HS_LO  = 7;
  localparam int CK_LO  = HS_LO + DIV_W;

  logic [15:0]      ctrl_q;
  logic [CNT_W-1:0] prd_act, prd_shd, prd_nxt, cnt_nxt;
  logic [PS_W-1:0]  ps_q, hs_fac, ps_total;
  logic             dir_q, dir_nxt, halted_q;
  logic [1:0]       mode, run;
  logic [DIV_W-1:0] hs_code, ck_code;
  logic             imm, tick, counting, adv, prd_wr, ctrl_wr;

  assign mode    = ctrl_q[1:0];
  assign run     = ctrl_q[15:14];
  assign imm     = ctrl_q[3];
  assign hs_code = ctrl_q[HS_LO +: DIV_W];
  assign ck_code = ctrl_q[CK_LO +: DIV_W];

  assign hs_fac   = (hs_code == '0) ? PS_W'(1) : PS_W'({hs_code, 1'b0});
  assign ps_total = hs_fac << ck_code;
  assign tick     = (ps_q >= ps_total - PS_W'(1));

  assign counting = !halted_q && (mode != 2'd3);
  assign adv      = tick && counting;
  assign zero_evt = adv && (cnt_q == '0);
  assign prd_evt  = adv && (cnt_q == prd_act);

  assign prd_wr  = wr_en && wr_sel;
  assign ctrl_wr = wr_en && !wr_sel;

  always_comb begin
    prd_nxt = prd_act;
    if (prd_wr && imm)
      prd_nxt = wr_data[CNT_W-1:0];
    else if (zero_evt && !imm)
      prd_nxt = prd_wr ? wr_data[CNT_W-1:0] : prd_shd;
  end

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    case (mode)
      2'd0: begin
        dir_nxt = 1'b0;
        cnt_nxt = (cnt_q >= prd_act) ? '0 : cnt_q + CNT_W'(1);
      end
      2'd1: begin
        dir_nxt = 1'b1;
        cnt_nxt = (cnt_q == '0) ? prd_nxt : cnt_q - CNT_W'(1);
      end
      2'd2: begin
        if (!dir_q) begin
          if (cnt_q >= prd_act) begin
            dir_nxt = 1'b1;
            cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
          end else begin
            cnt_nxt = cnt_q + CNT_W'(1);
          end
        end else begin
          if (cnt_q == '0) begin
            dir_nxt = 1'b0;
            cnt_nxt = (prd_nxt == '0) ? '0 : CNT_W'(1);
          end else begin
            cnt_nxt = cnt_q - CNT_W'(1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      prd_act  <= '0;
      prd_shd  <= '0;
      ps_q     <= '0;
      cnt_q    <= '0;
      dir_q    <= 1'b0;
      halted_q <= 1'b1;
    end else begin
      ps_q    <= tick ? '0 : ps_q + PS_W'(1);
      prd_act <= prd_nxt;
      if (prd_wr)  prd_shd <= wr_data[CNT_W-1:0];
      if (ctrl_wr) ctrl_q  <= wr_data;
      if (adv) begin
        cnt_q <= cnt_nxt;
        dir_q <= dir_nxt;
      end
      if (run[1])
        halted_q <= 1'b0;
      else if (adv && (run == 2'd0 || cnt_nxt == '0))
        halted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [15:0]      ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] prd_act,
  input logic             halted_q,
  input logic             zero_evt,
  input logic             prd_evt
);
  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == 2'd3) |=> (cnt_q == $past(cnt_q)));

  assert_freeze_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == 2'd3) |-> (!zero_evt && !prd_evt));

  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_evt && ctrl_q[1:0] == 2'd0) |=> (cnt_q == '0));

  assert_down_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && ctrl_q[1:0] == 2'd1 && ctrl_q[3] && !wr_en) |=> (cnt_q == $past(prd_act)));

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !ctrl_q[15]) |=> $stable(cnt_q));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_q(ctrl_q), .cnt_q(cnt_q),
  .prd_act(prd_act), .halted_q(halted_q), .zero_evt(zero_evt), .prd_evt(prd_evt)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_q;
  logic zero_evt, prd_evt;

  always #(CLK_P/2) clk = ~clk;

  pwm_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_q(cnt_q), .zero_evt(zero_evt), .prd_evt(prd_evt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  logic [15:0] m_ctrl, m_pact, m_pshd, m_cnt;
  logic m_dir, m_halt;
  int m_ps;

  function automatic int factor(input logic [15:0] c);
    int h = int'(c[9:7]);
    int k = int'(c[12:10]);
    return ((h == 0) ? 1 : 2 * h) * (1 << k);
  endfunction

  function automatic bit m_adv();
    return (m_ps >= factor(m_ctrl) - 1) && !m_halt && (m_ctrl[1:0] != 2'd3);
  endfunction

  task automatic model_edge(input bit we, input bit sel, input logic [15:0] d);
    bit tk = (m_ps >= factor(m_ctrl) - 1);
    bit adv = m_adv();
    logic [1:0] md = m_ctrl[1:0];
    logic [15:0] pn = m_pact;
    logic [15:0] cn = m_cnt;
    logic dn = m_dir;
    if (we && sel && m_ctrl[3]) pn = d;
    else if (adv && m_cnt == 0 && !m_ctrl[3]) pn = (we && sel) ? d : m_pshd;
    case (md)
      2'd0: begin dn = 1'b0; cn = (m_cnt >= m_pact) ? 16'd0 : m_cnt + 16'd1; end
      2'd1: begin dn = 1'b1; cn = (m_cnt == 0) ? pn : m_cnt - 16'd1; end
      2'd2: begin
        if (!m_dir) begin
          if (m_cnt >= m_pact) begin dn = 1'b1; cn = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
          else cn = m_cnt + 16'd1;
        end else begin
          if (m_cnt == 0) begin dn = 1'b0; cn = (pn == 0) ? 16'd0 : 16'd1; end
          else cn = m_cnt - 16'd1;
        end
      end
      default: ;
    endcase
    if (m_ctrl[15]) m_halt = 1'b0;
    else if (adv && (m_ctrl[15:14] == 2'd0 || cn == 0)) m_halt = 1'b1;
    if (adv) begin m_cnt = cn; m_dir = dn; end
    m_pact = pn;
    if (we && sel) m_pshd = d;
    if (we && !sel) m_ctrl = d;
    m_ps = tk ? 0 : m_ps + 1;
  endtask

  task automatic check_outputs();
    bit ez = m_adv() && (m_cnt == 0);
    bit ep = m_adv() && (m_cnt == m_pact);
    n_chk++;
    if (cnt_q !== m_cnt) begin
      n_fail++;
      $display("FAIL %s count: actual %0d expected %0d", cur_tag, cnt_q, m_cnt);
    end
    n_chk++;
    if (zero_evt !== ez || prd_evt !== ep) begin
      n_fail++;
      $display("FAIL R11 (%s) strobes zero/prd: actual %b%b expected %b%b",
               cur_tag, zero_evt, prd_evt, ez, ep);
    end
  endtask

  task automatic step(input bit we = 1'b0, input bit sel = 1'b0, input logic [15:0] d = 16'd0);
    wr_en = we; wr_sel = sel; wr_data = d;
    model_edge(we, sel, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_outputs();
  endtask

  task automatic run_steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (R1): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_ctrl = 0; m_pact = 0; m_pshd = 0; m_cnt = 0; m_dir = 0; m_halt = 1; m_ps = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    check_outputs();
    run_steps(5);

    cur_tag = "R9";
    step(1'b1, 1'b0, 16'hC008);
    step(1'b1, 1'b1, 16'd6);
    cur_tag = "R3";
    run_steps(20);

    cur_tag = "R2";
    step(1'b1, 1'b0, 16'hC008 | (16'd2 << 7) | (16'd1 << 10));
    run_steps(120);
    step(1'b1, 1'b0, 16'hC008 | (16'd7 << 10));
    run_steps(400);
    step(1'b1, 1'b0, 16'hC008);

    cur_tag = "R4";
    step(1'b1, 1'b0, 16'hC009);
    run_steps(40);

    cur_tag = "R5";
    step(1'b1, 1'b0, 16'hC00A);
    run_steps(60);

    cur_tag = "R6";
    step(1'b1, 1'b0, 16'hC00B);
    run_steps(20);

    cur_tag = "R7";
    step(1'b1, 1'b0, 16'hC008);
    run_steps(3);
    step(1'b1, 1'b0, 16'h0008);
    run_steps(20);
    step(1'b1, 1'b0, 16'h8008);
    run_steps(10);

    cur_tag = "R8";
    step(1'b1, 1'b0, 16'h4008);
    run_steps(30);

    cur_tag = "R10";
    step(1'b1, 1'b0, 16'hC000);
    step(1'b1, 1'b1, 16'd3);
    run_steps(20);
    for (int i = 0; i < 50 && !zero_evt; i++) step();
    step(1'b1, 1'b1, 16'd9);
    run_steps(30);
    step(1'b1, 1'b0, 16'hC001);
    for (int i = 0; i < 50 && !zero_evt; i++) step();
    step(1'b1, 1'b1, 16'd4);
    run_steps(20);

    for (int i = 0; i < 1500; i++) begin
      int r = $urandom_range(0, 99);
      case (m_ctrl[1:0])
        2'd0: cur_tag = "R3";
        2'd1: cur_tag = "R4";
        2'd2: cur_tag = "R5";
        default: cur_tag = "R6";
      endcase
      if (r < 4) begin
        logic [15:0] c;
        int rs = $urandom_range(0, 5);
        c = 16'(($urandom_range(0, 3)) | ($urandom_range(0, 1) << 3) |
                ($urandom_range(0, 2) << 7) | ($urandom_range(0, 1) << 10));
        c[15:14] = (rs == 0) ? 2'd0 : (rs == 1) ? 2'd1 : 2'd3;
        step(1'b1, 1'b0, c);
      end else if (r < 9) begin
        step(1'b1, 1'b1, 16'($urandom_range(0, 10)));
      end else begin
        step();
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule